// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller with Fast-Interrupt Routing

This block gathers 64 level-sensitive peripheral interrupt lines and 8 level-sensitive core-local lines. It drives two outputs to a processor. The normal request output rises whenever any line that is both asserted and enabled is present. The fast request output follows one line that software picks by number. Software reaches the block through a 32-bit register port. A single valid strobe qualifies each access, and a write-enable bit marks it as a write. Read data comes back registered, one clock later. Nothing is latched: every pending view is the live input level masked by its enable.

Each access is decoded into one of eleven access states, held in the enumeration `reg_sel_e`:

| State | Offset | Role |
|---|---|---|
| `SEL_SUMMARY` | 0x00 | summary pending view |
| `SEL_PEND_LO` | 0x04 | masked peripheral lines 0–31 |
| `SEL_PEND_HI` | 0x08 | masked peripheral lines 32–63 |
| `SEL_FAST_CTL` | 0x0C | fast-route control |
| `SEL_SET_LO` | 0x10 | enable-set, peripheral low bank |
| `SEL_SET_HI` | 0x14 | enable-set, peripheral high bank |
| `SEL_SET_CORE` | 0x18 | enable-set, core-local bank |
| `SEL_CLR_LO` | 0x1C | enable-clear, peripheral low bank |
| `SEL_CLR_HI` | 0x20 | enable-clear, peripheral high bank |
| `SEL_CLR_CORE` | 0x24 | enable-clear, core-local bank |
| `SEL_NONE` | any other | unmapped |

Every access lasts exactly one cycle, so there is no stored state sequence and no transitions between these states. The decode path leads from any access to exactly one of these states: `SEL_NONE` for unmapped offsets and one of the ten mapped states otherwise. A write that lands in a mask-set or mask-clear state moves that bank's enable register. A write that lands in `SEL_FAST_CTL` reloads the fast-route control. Any other write changes nothing.

Top module: `intc_dual_bank`

## Requirements
- R1: After reset, all enable masks read 0, the fast-route control (offset 0x0C) reads 0, and both `irq_out` and `fiq_out` are low.
- R2: Offsets 0x04 and 0x08 read the peripheral input levels ANDed with the enable mask. Offset 0x04 covers lines 0–31 and offset 0x08 covers lines 32–63, with bit i of each word holding line (32·bank + i).
- R3: A write to 0x10, 0x14 or 0x18 ORs the written word into the enable mask of the low peripheral bank, high peripheral bank or core-local bank respectively. Only bits 7:0 apply to the core-local bank. Reading these offsets returns the mask, zero-extended.
- R4: A write to 0x1C, 0x20 or 0x24 clears every mask bit of the corresponding bank that is written as 1. Reading these offsets returns the bitwise inverse of the 32-bit zero-extended mask, so the core-local read has bits 31:8 set.
- R5: Offset 0x00 reads as follows. Bits 7:0 hold the core-local lines ANDed with their enables. Bit 8 is the OR of the masked low peripheral bank, and bit 9 is the OR of the masked high bank. Bits 10 to 20 hold the masked state of peripheral lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, in that order. Bits 31:21 read 0.
- R6: In the fast-route control, bits 6:0 are the select and bit 7 is the enable; the register reads back as written in bits 7:0. When enabled, `fiq_out` follows the raw level of the selected line and ignores the enable masks. Selects 0–63 pick peripheral lines, selects 64–71 pick core-local line (select − 64), and selects 72–127 give 0. When the enable is clear, `fiq_out` is low.
- R7: `irq_out` is high exactly when some enabled peripheral or enabled core-local line is asserted.
- R8: A read from an unmapped or misaligned offset returns 0. A write to an unmapped offset or to offsets 0x00, 0x04 or 0x08 changes no register.
- R9: `irq_out` and `fiq_out` are registered. They reflect an input change at the next clock edge and a register write one edge after the edge that takes the write. Read data appears one edge after the request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_valid | input | 1 | register access strobe, one cycle per access |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (9) | byte offset |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | registered read data |
| periph_irq | input | PERIPH_N (64) | peripheral interrupt levels |
| core_irq | input | CORE_N (8) | core-local interrupt levels |
| irq_out | output | 1 | normal interrupt request |
| fiq_out | output | 1 | fast interrupt request |

## Verification
The bench builds the block with its default values: 64 peripheral lines, 8 core-local lines and a 9-bit offset. With these values both peripheral banks, the full 7-bit fast select space and every mirrored summary line can be reached. Fast selects above the last core-local line can therefore be driven, and the bench confirms they yield no request. The bench also reaches an unmapped offset near the top of the 512-byte window. Because both peripheral banks exist, the bench can show the upper-bank summary flag rising while the mirrored line 62 shows at bit 20 and line 63 stays out of the mirror.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int REG_W      = 32;
    localparam int BANK_W     = 32;
    localparam int FAST_SEL_W = 7;
    localparam int SUM_LO_BIT = 8;
    localparam int SUM_HI_BIT = 9;
    localparam int SUM_MIR_BIT = 10;
    localparam int MIRROR_N   = 11;

    typedef enum logic [3:0] {
        SEL_SUMMARY,
        SEL_PEND_LO,
        SEL_PEND_HI,
        SEL_FAST_CTL,
        SEL_SET_LO,
        SEL_SET_HI,
        SEL_SET_CORE,
        SEL_CLR_LO,
        SEL_CLR_HI,
        SEL_CLR_CORE,
        SEL_NONE
    } reg_sel_e;

    // byte offset to access state; misaligned or unknown offsets land in SEL_NONE
    function automatic reg_sel_e decode_sel(input logic [31:0] off);
        reg_sel_e s;
        unique case (off)
            32'h00:  s = SEL_SUMMARY;
            32'h04:  s = SEL_PEND_LO;
            32'h08:  s = SEL_PEND_HI;
            32'h0C:  s = SEL_FAST_CTL;
            32'h10:  s = SEL_SET_LO;
            32'h14:  s = SEL_SET_HI;
            32'h18:  s = SEL_SET_CORE;
            32'h1C:  s = SEL_CLR_LO;
            32'h20:  s = SEL_CLR_HI;
            32'h24:  s = SEL_CLR_CORE;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    // peripheral line shown at summary bit (SUM_MIR_BIT + k)
    function automatic int mirror_src(input int k);
        int r;
        case (k)
            0:       r = 7;
            1:       r = 9;
            2:       r = 10;
            3:       r = 18;
            4:       r = 19;
            5:       r = 53;
            6:       r = 54;
            7:       r = 55;
            8:       r = 56;
            9:       r = 57;
            default: r = 62;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/intc_enable_bank.sv
module intc_enable_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (set_we) begin
            mask <= mask | wdata;
        end else if (clr_we) begin
            mask <= mask & ~wdata;
        end
    end

    // R3: a set write keeps old bits and adds the written ones
    a_r3_set_accumulates: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((mask & ($past(mask) | $past(wdata))) == ($past(mask) | $past(wdata))));

    // R4: a clear write leaves no written-1 bit enabled
    a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((mask & $past(wdata)) == '0));

endmodule

// File: rtl/intc_fast_route.sv
module intc_fast_route
    import intc_pkg::*;
#(
    parameter int PERIPH_N = 64,
    parameter int CORE_N   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic [7:0]          ctl_wdata,
    input  logic [PERIPH_N-1:0] periph_lvl,
    input  logic [CORE_N-1:0]   core_lvl,
    output logic [7:0]          ctl_q,
    output logic                fast_lvl
);

    localparam int TOTAL_N = PERIPH_N + CORE_N;
    localparam int SPAN    = 1 << FAST_SEL_W;

    logic [SPAN-1:0]       all_lvl;
    logic [FAST_SEL_W-1:0] sel;
    logic                  en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q <= ctl_wdata;
        end
    end

    assign sel     = ctl_q[FAST_SEL_W-1:0];
    assign en      = ctl_q[7];
    // core lines sit just above the peripheral lines; the rest of the span is zero
    assign all_lvl = SPAN'({core_lvl, periph_lvl});

    always_comb begin
        fast_lvl = en & all_lvl[sel];
    end

    // R6: selects past the last core-local line route nothing
    a_r6_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel) >= TOTAL_N) |-> !fast_lvl);

endmodule

// File: rtl/intc_reg_read.sv
module intc_reg_read
    import intc_pkg::*;
#(
    parameter int PERIPH_N = 64,
    parameter int CORE_N   = 8
) (
    input  reg_sel_e            sel,
    input  logic [PERIPH_N-1:0] periph_lvl,
    input  logic [PERIPH_N-1:0] periph_en,
    input  logic [CORE_N-1:0]   core_lvl,
    input  logic [CORE_N-1:0]   core_en,
    input  logic [7:0]          fast_ctl,
    output logic [REG_W-1:0]    rdata
);

    logic [PERIPH_N-1:0] pend;
    logic [CORE_N-1:0]   core_pend;
    logic [MIRROR_N-1:0] mirror;
    logic [REG_W-1:0]    summary;

    assign pend      = periph_lvl & periph_en;
    assign core_pend = core_lvl & core_en;

    for (genvar k = 0; k < MIRROR_N; k++) begin : g_mirror
        assign mirror[k] = pend[mirror_src(k)];
    end

    always_comb begin
        summary                                  = '0;
        summary[CORE_N-1:0]                      = core_pend;
        summary[SUM_LO_BIT]                      = |pend[BANK_W-1:0];
        summary[SUM_HI_BIT]                      = |pend[PERIPH_N-1:BANK_W];
        summary[SUM_MIR_BIT +: MIRROR_N]         = mirror;
    end

    always_comb begin
        unique case (sel)
            SEL_SUMMARY:  rdata = summary;
            SEL_PEND_LO:  rdata = pend[BANK_W-1:0];
            SEL_PEND_HI:  rdata = pend[PERIPH_N-1:BANK_W];
            SEL_FAST_CTL: rdata = REG_W'(fast_ctl);
            SEL_SET_LO:   rdata = periph_en[BANK_W-1:0];
            SEL_SET_HI:   rdata = periph_en[PERIPH_N-1:BANK_W];
            SEL_SET_CORE: rdata = REG_W'(core_en);
            SEL_CLR_LO:   rdata = ~periph_en[BANK_W-1:0];
            SEL_CLR_HI:   rdata = ~periph_en[PERIPH_N-1:BANK_W];
            SEL_CLR_CORE: rdata = ~(REG_W'(core_en));
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/intc_dual_bank.sv
module intc_dual_bank
    import intc_pkg::*;
#(
    parameter int PERIPH_N = 64,
    parameter int CORE_N   = 8,
    parameter int ADDR_W   = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_valid,
    input  logic                reg_write,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [PERIPH_N-1:0] periph_irq,
    input  logic [CORE_N-1:0]   core_irq,
    output logic                irq_out,
    output logic                fiq_out
);

    localparam int NBANK = PERIPH_N / BANK_W;

    reg_sel_e            sel;
    logic                wr;
    logic                rd;
    logic [PERIPH_N-1:0] periph_en;
    logic [CORE_N-1:0]   core_en;
    logic [7:0]          fast_ctl;
    logic                fast_lvl;
    logic [REG_W-1:0]    rd_mux;
    logic                any_req;
    logic [NBANK-1:0]    set_p;
    logic [NBANK-1:0]    clr_p;
    logic                set_c;
    logic                clr_c;
    logic                ctl_we;

    assign sel = decode_sel(32'(reg_addr));
    assign wr  = reg_valid & reg_write;
    assign rd  = reg_valid & ~reg_write;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam reg_sel_e SET_S = (b == 0) ? SEL_SET_LO : SEL_SET_HI;
        localparam reg_sel_e CLR_S = (b == 0) ? SEL_CLR_LO : SEL_CLR_HI;
        assign set_p[b] = wr && (sel == SET_S);
        assign clr_p[b] = wr && (sel == CLR_S);
        intc_enable_bank #(.W(BANK_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (set_p[b]),
            .clr_we (clr_p[b]),
            .wdata  (reg_wdata),
            .mask   (periph_en[b*BANK_W +: BANK_W])
        );
    end

    assign set_c  = wr && (sel == SEL_SET_CORE);
    assign clr_c  = wr && (sel == SEL_CLR_CORE);
    assign ctl_we = wr && (sel == SEL_FAST_CTL);

    intc_enable_bank #(.W(CORE_N)) u_core_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (set_c),
        .clr_we (clr_c),
        .wdata  (reg_wdata[CORE_N-1:0]),
        .mask   (core_en)
    );

    intc_fast_route #(.PERIPH_N(PERIPH_N), .CORE_N(CORE_N)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .ctl_wdata  (reg_wdata[7:0]),
        .periph_lvl (periph_irq),
        .core_lvl   (core_irq),
        .ctl_q      (fast_ctl),
        .fast_lvl   (fast_lvl)
    );

    intc_reg_read #(.PERIPH_N(PERIPH_N), .CORE_N(CORE_N)) u_read (
        .sel        (sel),
        .periph_lvl (periph_irq),
        .periph_en  (periph_en),
        .core_lvl   (core_irq),
        .core_en    (core_en),
        .fast_ctl   (fast_ctl),
        .rdata      (rd_mux)
    );

    assign any_req = (|(periph_irq & periph_en)) | (|(core_irq & core_en));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_out   <= 1'b0;
            fiq_out   <= 1'b0;
            reg_rdata <= '0;
        end else begin
            irq_out <= any_req;
            fiq_out <= fast_lvl;
            if (rd) begin
                reg_rdata <= rd_mux;
            end
        end
    end

    // R1: outputs are quiet on the first edge out of reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (!irq_out && !fiq_out && reg_rdata == '0));

    // R7: no asserted line means no normal request one edge later
    a_r7_no_src_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_irq == '0 && core_irq == '0) |=> !irq_out);

    // R6: a disabled fast route gives a low fast request one edge later
    a_r6_fast_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_ctl[7] |=> !fiq_out);

    // R8: at most one register moves per access
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_p, clr_p, set_c, clr_c, ctl_we}));

    // R9: read data holds between reads
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(reg_rdata));

endmodule

// File: tb/intc_dual_bank_bench.sv
`timescale 1ns/1ps
module intc_dual_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] periph_irq = '0;
    logic [7:0]  core_irq = '0;
    logic        irq_out;
    logic        fiq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t sb[$];
    logic      rd_fire_q = 1'b0;

    always #2.5 clk = ~clk;

    intc_dual_bank u_intc_dual_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_valid  (reg_valid),
        .reg_write  (reg_write),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .periph_irq (periph_irq),
        .core_irq   (core_irq),
        .irq_out    (irq_out),
        .fiq_out    (fiq_out)
    );

    // monitor: a read requested before an edge is compared on the following falling edge
    always @(posedge clk) rd_fire_q <= reg_valid && !reg_write;

    always @(negedge clk) begin
        if (rd_fire_q) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read data %h with nothing expected", reg_rdata);
            end else begin
                exp_item_t it;
                it = sb.pop_front();
                if (reg_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: read got %h expected %h", it.tag, reg_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        @(negedge clk);
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
    endtask

    task automatic chk(input string tag, input logic got, input logic e);
        checks++;
        if (got !== e) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, e);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq_out after reset", irq_out, 1'b0);
        chk("R1 fiq_out after reset", fiq_out, 1'b0);
        rd(9'h10, 32'h0, "R1 set-low mask");
        rd(9'h14, 32'h0, "R1 set-high mask");
        rd(9'h18, 32'h0, "R1 core mask");
        rd(9'h0C, 32'h0, "R1 fast control");

        // lines 0, 7, 63 and core 0, 2 asserted, nothing enabled
        @(negedge clk);
        periph_irq = 64'h8000_0000_0000_0081;
        core_irq   = 8'h05;
        rd(9'h04, 32'h0, "R2 pending low with no enables");
        chk("R7 irq_out with no enables", irq_out, 1'b0);

        wr(9'h10, 32'h0000_0081);
        wr(9'h10, 32'h0000_0100);
        rd(9'h10, 32'h0000_0181, "R3 set-low accumulates");
        rd(9'h1C, 32'hFFFF_FE7E, "R4 clear-low reads inverse");
        rd(9'h04, 32'h0000_0081, "R2 pending low masked");
        chk("R7 irq_out with enabled line", irq_out, 1'b1);
        rd(9'h00, 32'h0000_0500, "R5 summary low flag and line 7 mirror");

        wr(9'h14, 32'h8000_0000);
        @(negedge clk);
        periph_irq[62] = 1'b1;
        wr(9'h14, 32'h4000_0000);
        rd(9'h08, 32'hC000_0000, "R2 pending high masked");
        rd(9'h00, 32'h0010_0700, "R5 summary high flag and line 62 mirror");

        wr(9'h18, 32'hFFFF_FF05);
        rd(9'h18, 32'h0000_0005, "R3 core mask takes low 8 bits only");
        rd(9'h24, 32'hFFFF_FFFA, "R4 core clear reads inverse");
        rd(9'h00, 32'h0010_0705, "R5 summary core bits");

        wr(9'h1C, 32'h0000_0001);
        rd(9'h10, 32'h0000_0180, "R4 clear-low drops written bit");
        wr(9'h1C, 32'hFFFF_FFFF);
        wr(9'h20, 32'hFFFF_FFFF);
        wr(9'h24, 32'h0000_00FF);
        rd(9'h14, 32'h0, "R4 clear-high empties mask");
        settle();
        chk("R7 irq_out after all masks cleared", irq_out, 1'b0);

        // writes that must change nothing
        wr(9'h04, 32'hFFFF_FFFF);
        wr(9'h00, 32'hFFFF_FFFF);
        wr(9'h28, 32'hFFFF_FFFF);
        wr(9'h1FC, 32'hFFFF_FFFF);
        wr(9'h11, 32'hFFFF_FFFF);
        rd(9'h10, 32'h0, "R8 set-low untouched by stray writes");
        rd(9'h14, 32'h0, "R8 set-high untouched by stray writes");
        rd(9'h18, 32'h0, "R8 core mask untouched by stray writes");
        rd(9'h0C, 32'h0, "R8 fast control untouched by stray writes");
        rd(9'h28, 32'h0, "R8 unmapped read");
        rd(9'h1FC, 32'h0, "R8 top unmapped read");
        rd(9'h05, 32'h0, "R8 misaligned read");
        settle();
        chk("R8 irq_out after stray writes", irq_out, 1'b0);

        // timing of a write reaching irq_out
        wr(9'h10, 32'h0000_0080);
        chk("R9 irq_out not yet updated", irq_out, 1'b0);
        @(negedge clk);
        chk("R9 irq_out one edge after write", irq_out, 1'b1);
        wr(9'h1C, 32'h0000_0080);

        // fast route to peripheral line 7, masks all clear
        wr(9'h0C, 32'h0000_0087);
        rd(9'h0C, 32'h0000_0087, "R6 fast control readback");
        settle();
        chk("R6 fiq_out follows raw line ignoring masks", fiq_out, 1'b1);
        periph_irq[7] = 1'b0;
        @(negedge clk);
        chk("R9 fiq_out one edge after input fall", fiq_out, 1'b0);
        periph_irq[7] = 1'b1;
        @(negedge clk);
        chk("R9 fiq_out one edge after input rise", fiq_out, 1'b1);

        // core-local selection
        wr(9'h0C, 32'h0000_00C2);
        settle();
        chk("R6 fiq_out from core line 2", fiq_out, 1'b1);
        core_irq[2] = 1'b0;
        settle();
        chk("R6 fiq_out core line 2 low", fiq_out, 1'b0);
        core_irq = 8'hFF;
        periph_irq = '1;
        wr(9'h0C, 32'h0000_00C8);
        settle();
        chk("R6 fiq_out select 72 routes nothing", fiq_out, 1'b0);
        wr(9'h0C, 32'h0000_0007);
        settle();
        chk("R6 fiq_out disabled", fiq_out, 1'b0);
        chk("R7 irq_out with all lines up and no enables", irq_out, 1'b0);

        settle();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule